// File: doc/BRIEF.md
# Lockable Instruction Cache with Critical-Word-First Refill

This block is a 16 KB instruction cache placed between a processor fetch port and a slow on-chip flash that returns 128 bits per read beat. It answers fetches that hit in the same cycle. When a fetch misses, the block holds the processor stalled and reads the 32-byte line from flash in two beats. It asks first for the beat that holds the missing word and hands that word to the processor when it arrives. It then reads the other half of the line, with the beat address wrapping within the line.

For time-critical code, software can pin ways of the cache with a 4-bit lock mask. A way that is pinned is never picked for replacement, so code loaded into it keeps hitting at full speed. To load code into a chosen way before it is pinned, a preload control forces the next allocations into a way that software selects. Replacement steps round-robin over the unpinned ways. When every way is pinned, a miss is served straight from flash and nothing is allocated. A one-cycle invalidate-all pulse empties every unpinned way and leaves pinned contents in place.

Top module: `lockable_icache`

## Requirements
- R1: A fetch whose line is resident asserts `fetch_valid` in the same cycle with the addressed word on `fetch_data`. `fetch_stall` stays low and the fetch issues no flash request.
- R2: On a miss, `fetch_stall` stays high and `fetch_valid` stays low until the missing word arrives. `flash_req` pulses in the cycle after the miss is seen. The word is delivered in the cycle that `flash_rvalid` returns it, which is the flash latency plus two cycles after the fetch was raised.
- R3: The first flash request of a refill addresses the 16-byte beat that holds the missed word, with `flash_addr` equal to the fetch address with bits [3:0] cleared. The word that is forwarded comes from bits [32k+31:32k] of `flash_rdata`, where k = fetch address bits [3:2].
- R4: After the critical beat, the other beat of the 32-byte line is requested at the first beat address XOR 0x10. Only one request is outstanding at a time: `flash_req` is a single-cycle pulse, and the next pulse comes only after `flash_rvalid`.
- R5: Once a refill has completed, all eight words of that line hit.
- R6: `lock_we` loads `lock_wdata` into the lock mask, where bit w pins way w. A pinned way is never chosen as a victim, and lines held in it keep hitting.
- R7: Victims are chosen round-robin through one pointer shared by all sets, which starts at 0 after reset. The victim is the first unpinned way at or after the pointer, and the pointer then moves to victim+1 mod 4. Ways are indexed by address bits [11:5].
- R8: When all four ways are pinned and preload is off, a miss makes exactly one flash request, is served from it, and allocates nothing, so the same fetch misses again.
- R9: While `preload_en` is high, a miss allocates into `preload_way` even if that way is pinned, and the round-robin pointer does not move.
- R10: A one-cycle `inv_all` pulse clears every line in unpinned ways and leaves lines in pinned ways valid.
- R11: After reset, every line is invalid and the lock mask is 0. While no fetch is pending, `flash_req`, `fetch_valid` and `fetch_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Processor fetch request, held until `fetch_valid` |
| fetch_addr | input | 32 | Fetch byte address, held with the request |
| fetch_valid | output | 1 | Fetch data valid this cycle |
| fetch_stall | output | 1 | Fetch pending and not yet served |
| fetch_data | output | 32 | Instruction word |
| flash_req | output | 1 | Single-cycle beat read request |
| flash_addr | output | 32 | 16-byte aligned beat address |
| flash_rvalid | input | 1 | Beat read data valid |
| flash_rdata | input | 128 | Beat read data, word k in bits [32k+31:32k] |
| lock_we | input | 1 | Load the lock mask |
| lock_wdata | input | 4 | New lock mask, bit w pins way w |
| preload_en | input | 1 | Force allocation into `preload_way` |
| preload_way | input | 2 | Way to allocate into during preload |
| inv_all | input | 1 | Invalidate every unpinned line |

## Verification
The assertions assume three things about the inputs. The processor keeps `fetch_req` and `fetch_addr` steady from request until `fetch_valid`. The flash returns exactly one `flash_rvalid` per request, at least one cycle after it. `inv_all` is pulsed only while no refill is in flight. The bench's flash model answers each request after a fixed three-cycle latency and returns data computed from the address. The bench lowers the fetch only after it has been served, and then waits long enough for any trailing refill beat to finish before it changes the lock mask, preload or invalidate, or starts the next fetch.

// File: rtl/lic_pkg.sv
// Package shared by the lockable instruction cache.
// It holds the refill sequencer state type. It assumes nothing.
package lic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fill_state_t;
endpackage

// File: rtl/lic_tag_array.sv
// Tag and valid store for every way, plus the per-way hit compare.
// A write either clears the valid bit of one entry or stores a tag and sets it.
// Invalidate-all clears every way whose lock bit is low.
// Assumes SETS is a power of two and that only one line is ever allocated per address.
module lic_tag_array #(
    parameter int WAYS  = 4,
    parameter int SETS  = 128,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  hit_vec,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [IDX_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid,
    input  logic             inv_all,
    input  logic [WAYS-1:0]  lock_mask
);
    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_way
            logic [TAG_W-1:0] tag_mem [SETS];
            logic [SETS-1:0]  vld_q;
            logic             sel;

            assign sel = wr_en && (wr_way == WAY_W'(w));
            assign hit_vec[w] = vld_q[lk_set] && (tag_mem[lk_set] == lk_tag);

            // Valid bits: reset clear, per-entry write, or bulk clear if unpinned.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= '0;
                end else if (sel) begin
                    vld_q[wr_set] <= wr_valid;
                end else if (inv_all && !lock_mask[w]) begin
                    vld_q <= '0;
                end
            end

            // Tag storage: written on each write to this way.
            always_ff @(posedge clk) begin
                if (sel) tag_mem[wr_set] <= wr_tag;
            end

            AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (inv_all && !lock_mask[w] && !sel) |=> (vld_q == '0)); // R10
            AST_INV_KEEPS_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
                (inv_all && lock_mask[w] && !sel) |=> $stable(vld_q)); // R10
        end
    endgenerate

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R1
endmodule

// File: rtl/lic_data_array.sv
// Line data store, organised as one 128-bit entry per (set, way, beat).
// It has a single write port and an asynchronous read port.
// Assumes that SETS, WAYS and BEATS are powers of two.
module lic_data_array #(
    parameter int WAYS   = 4,
    parameter int SETS   = 128,
    parameter int BEATS  = 2,
    parameter int BEAT_W = 128,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int BIDX_W = $clog2(BEATS),
    localparam int A_W    = IDX_W + WAY_W + BIDX_W,
    localparam int DEPTH  = SETS * WAYS * BEATS
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [BIDX_W-1:0] wr_beat,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [BIDX_W-1:0] rd_beat,
    output logic [BEAT_W-1:0] rd_data
);
    logic [BEAT_W-1:0] mem [DEPTH];
    logic [A_W-1:0]    wa;
    logic [A_W-1:0]    ra;

    assign wa = {wr_set, wr_way, wr_beat};
    assign ra = {rd_set, rd_way, rd_beat};
    assign rd_data = mem[ra];

    // Store a refill beat.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wa] <= wr_data;
    end
endmodule

// File: rtl/lic_victim_pick.sv
// Chooses the way to refill. It scans from the round-robin pointer for the first
// way that is not pinned. The forced preload way overrides the scan.
// alloc_ok is low when every way is pinned and there is no forcing.
// Assumes WAYS is a power of two, so the pointer wraps naturally.
module lic_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  lock_mask,
    input  logic [WAY_W-1:0] rr_ptr,
    input  logic             force_en,
    input  logic [WAY_W-1:0] force_way,
    output logic [WAY_W-1:0] victim,
    output logic             alloc_ok
);
    logic [WAY_W-1:0] cand;

    // Scan from the highest offset down, so the nearest unpinned way wins.
    always_comb begin
        victim   = rr_ptr;
        alloc_ok = 1'b0;
        cand     = '0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            cand = rr_ptr + WAY_W'(k);
            if (!lock_mask[cand]) begin
                victim   = cand;
                alloc_ok = 1'b1;
            end
        end
        if (force_en) begin
            victim   = force_way;
            alloc_ok = 1'b1;
        end
    end
endmodule

// File: rtl/lockable_icache.sv
// Set-associative instruction cache with pinnable ways and a wrapped refill.
// A hit is answered combinationally. A miss runs one line fill at a time, one flash
// beat per request, starting at the critical beat. The missed word is forwarded
// as its beat arrives.
// Assumes: fetch_req and fetch_addr are held until fetch_valid, the flash answers
// each request with exactly one rvalid, and inv_all is pulsed only when idle.
module lockable_icache #(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_W     = 128,
    parameter int WORD_W     = 32,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int IDX_W      = $clog2(SETS),
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int BEAT_BYTES = BEAT_W / 8,
    localparam int BEAT_OFF_W = $clog2(BEAT_BYTES),
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
    localparam int BIDX_W     = $clog2(BEATS),
    localparam int WPB        = BEAT_W / WORD_W,
    localparam int WSEL_W     = $clog2(WPB),
    localparam int BYTE_W     = $clog2(WORD_W / 8),
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid,
    output logic              fetch_stall,
    output logic [WORD_W-1:0] fetch_data,
    output logic              flash_req,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic              flash_rvalid,
    input  logic [BEAT_W-1:0] flash_rdata,
    input  logic              lock_we,
    input  logic [WAYS-1:0]   lock_wdata,
    input  logic              preload_en,
    input  logic [WAY_W-1:0]  preload_way,
    input  logic              inv_all
);
    import lic_pkg::*;

    fill_state_t       state_q;
    logic [ADDR_W-1:0] fill_addr_q;
    logic [WAY_W-1:0]  fill_way_q;
    logic              alloc_q;
    logic [BIDX_W-1:0] cnt_q;
    logic [WAY_W-1:0]  rr_q;
    logic [WAYS-1:0]   lock_q;

    logic [IDX_W-1:0]  lk_set, fill_set;
    logic [TAG_W-1:0]  lk_tag, fill_tag;
    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic              alloc_ok;
    logic              miss_start;
    logic              beat_in;
    logic              fwd;
    logic              fill_last;
    logic [BIDX_W-1:0] cur_beat;
    logic              tag_we;
    logic [WAY_W-1:0]  tag_wway;
    logic [IDX_W-1:0]  tag_wset;
    logic [TAG_W-1:0]  tag_wtag;
    logic [BEAT_W-1:0] rd_beat_data;
    logic [BEAT_W-1:0] src_beat;
    logic [WSEL_W-1:0] word_sel;
    logic              unused_bits;

    assign lk_set   = fetch_addr[OFF_W +: IDX_W];
    assign lk_tag   = fetch_addr[ADDR_W-1 -: TAG_W];
    assign fill_set = fill_addr_q[OFF_W +: IDX_W];
    assign fill_tag = fill_addr_q[ADDR_W-1 -: TAG_W];
    assign hit      = |hit_vec;
    assign cur_beat = fill_addr_q[OFF_W-1:BEAT_OFF_W] + cnt_q;

    assign miss_start = (state_q == ST_IDLE) && fetch_req && !hit;
    assign beat_in    = (state_q == ST_WAIT) && flash_rvalid;
    assign fwd        = beat_in && (cnt_q == '0);
    assign fill_last  = beat_in && alloc_q && (cnt_q == BIDX_W'(BEATS - 1));

    assign flash_req  = (state_q == ST_ISSUE);
    assign flash_addr = {fill_addr_q[ADDR_W-1:OFF_W], cur_beat, {BEAT_OFF_W{1'b0}}};

    assign fetch_valid = fetch_req && (hit || fwd);
    assign fetch_stall = fetch_req && !fetch_valid;

    // Tag port: clear the victim entry when a fill starts, set it when the fill ends.
    assign tag_we   = (miss_start && alloc_ok) || fill_last;
    assign tag_wway = miss_start ? victim : fill_way_q;
    assign tag_wset = miss_start ? lk_set : fill_set;
    assign tag_wtag = miss_start ? lk_tag : fill_tag;

    assign unused_bits = ^{fetch_addr[BYTE_W-1:0], fill_addr_q[BYTE_W-1:0]};

    // One-hot hit vector to way number.
    always_comb begin
        hit_way = '0;
        for (int k = 0; k < WAYS; k++) begin
            if (hit_vec[k]) hit_way = WAY_W'(k);
        end
    end

    // Choose the word from the flash beat (forward) or the stored beat (hit).
    always_comb begin
        src_beat   = fwd ? flash_rdata : rd_beat_data;
        word_sel   = fwd ? fill_addr_q[BEAT_OFF_W-1:BYTE_W] : fetch_addr[BEAT_OFF_W-1:BYTE_W];
        fetch_data = '0;
        for (int k = 0; k < WPB; k++) begin
            if (word_sel == WSEL_W'(k)) fetch_data = src_beat[k*WORD_W +: WORD_W];
        end
    end

    // Lock mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else if (lock_we) lock_q <= lock_wdata;
    end

    // Refill sequencer and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            fill_addr_q <= '0;
            fill_way_q  <= '0;
            alloc_q     <= 1'b0;
            cnt_q       <= '0;
            rr_q        <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (miss_start) begin
                        fill_addr_q <= fetch_addr;
                        fill_way_q  <= victim;
                        alloc_q     <= alloc_ok;
                        cnt_q       <= '0;
                        state_q     <= ST_ISSUE;
                        if (alloc_ok && !preload_en) rr_q <= victim + WAY_W'(1);
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (flash_rvalid) begin
                        if (alloc_q && (cnt_q != BIDX_W'(BEATS - 1))) begin
                            cnt_q   <= cnt_q + BIDX_W'(1);
                            state_q <= ST_ISSUE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    lic_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (lk_set),
        .lk_tag    (lk_tag),
        .hit_vec   (hit_vec),
        .wr_en     (tag_we),
        .wr_way    (tag_wway),
        .wr_set    (tag_wset),
        .wr_tag    (tag_wtag),
        .wr_valid  (fill_last),
        .inv_all   (inv_all),
        .lock_mask (lock_q)
    );

    lic_data_array #(.WAYS(WAYS), .SETS(SETS), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_data (
        .clk     (clk),
        .wr_en   (beat_in && alloc_q),
        .wr_set  (fill_set),
        .wr_way  (fill_way_q),
        .wr_beat (cur_beat),
        .wr_data (flash_rdata),
        .rd_set  (lk_set),
        .rd_way  (hit_way),
        .rd_beat (fetch_addr[OFF_W-1:BEAT_OFF_W]),
        .rd_data (rd_beat_data)
    );

    lic_victim_pick #(.WAYS(WAYS)) u_victim (
        .lock_mask (lock_q),
        .rr_ptr    (rr_q),
        .force_en  (preload_en),
        .force_way (preload_way),
        .victim    (victim),
        .alloc_ok  (alloc_ok)
    );

    AST_HIT_NO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fetch_req && hit) |=> !flash_req); // R1
    AST_MISS_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        miss_start |=> flash_req); // R2
    AST_CRIT_BEAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && cnt_q == '0) |-> (flash_addr[OFF_W-1:BEAT_OFF_W] == fetch_addr[OFF_W-1:BEAT_OFF_W])); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |=> !flash_req); // R4
    AST_PINNED_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_start && alloc_ok && !preload_en) |-> !lock_q[victim]); // R6
    AST_UNCACHED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_in && !alloc_q) |=> (!flash_req && state_q == ST_IDLE)); // R8
endmodule

// File: tb/tb_lockable_icache.sv
module tb_lockable_icache;
    localparam int LAT = 3;
    localparam int NV  = 11;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h0000_1004, 32'h0000_101C, 32'h0000_2018, 32'h0000_1008, 32'h0000_0044,
        32'h0000_2000, 32'h0000_3000, 32'h0000_4010, 32'h0000_1000, 32'h0000_2004,
        32'h0000_4000};
    localparam int V_REQS [NV] = '{2, 0, 2, 0, 2, 0, 2, 2, 2, 2, 0};

    logic         clk = 1'b0;
    logic         rst_n;
    logic         fetch_req;
    logic [31:0]  fetch_addr;
    logic         fetch_valid, fetch_stall;
    logic [31:0]  fetch_data;
    logic         flash_req;
    logic [31:0]  flash_addr;
    logic         flash_rvalid;
    logic [127:0] flash_rdata;
    logic         lock_we;
    logic [3:0]   lock_wdata;
    logic         preload_en;
    logic [1:0]   preload_way;
    logic         inv_all;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lockable_icache dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_stall(fetch_stall), .fetch_data(fetch_data),
        .flash_req(flash_req), .flash_addr(flash_addr), .flash_rvalid(flash_rvalid),
        .flash_rdata(flash_rdata), .lock_we(lock_we), .lock_wdata(lock_wdata),
        .preload_en(preload_en), .preload_way(preload_way), .inv_all(inv_all)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_0F00;
    endfunction

    function automatic logic [127:0] beat_of(input logic [31:0] a);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) r[32*k +: 32] = word_of({a[31:4], 4'h0} + 32'(4 * k));
        return r;
    endfunction

    // Flash model: fixed latency, one beat per request, logs request addresses.
    int          req_total = 0;
    logic [31:0] req_log [256];
    logic [31:0] pend_addr;
    int          lat_cnt = 0;
    bit          overlap = 1'b0;
    always @(posedge clk) begin
        flash_rvalid <= 1'b0;
        if (flash_req) begin
            if (lat_cnt != 0) overlap <= 1'b1;
            pend_addr <= flash_addr;
            lat_cnt   <= LAT;
            req_log[req_total % 256] <= flash_addr;
            req_total <= req_total + 1;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                flash_rvalid <= 1'b1;
                flash_rdata  <= beat_of(pend_addr);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [31:0] r_data, r_first, r_second;
    int          r_wait, r_reqs;
    bit          r_stall_ok;

    task automatic do_reset();
        rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = '0; lock_we = 1'b0;
        lock_wdata = '0; preload_en = 1'b0; preload_way = '0; inv_all = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fetch(input logic [31:0] a);
        int start;
        start = req_total;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; r_wait = 0; r_stall_ok = 1'b1;
        #2;
        while (!fetch_valid && r_wait < 500) begin
            if (!fetch_stall) r_stall_ok = 1'b0;
            @(negedge clk); #2;
            r_wait++;
        end
        r_data = fetch_data;
        @(negedge clk);
        fetch_req = 1'b0;
        repeat (3 * LAT + 8) @(negedge clk);
        r_reqs   = req_total - start;
        r_first  = req_log[start % 256];
        r_second = req_log[(start + 1) % 256];
    endtask

    task automatic expect_fetch(input logic [31:0] a, input int exp_reqs, input string req);
        fetch(a);
        check(r_data == word_of(a), "R3", "fetch word", r_data, word_of(a));
        check(r_reqs == exp_reqs, req, "flash request count", 32'(r_reqs), 32'(exp_reqs));
        if (exp_reqs == 0) begin
            check(r_wait == 0, "R1", "hit latency", 32'(r_wait), 32'd0);
        end else begin
            check(r_wait == LAT + 2 && r_stall_ok, "R2", "miss stall cycles",
                  32'(r_wait), 32'(LAT + 2));
            check(r_first == {a[31:4], 4'h0}, "R3", "critical beat address",
                  r_first, {a[31:4], 4'h0});
        end
        if (exp_reqs == 2)
            check(r_second == (r_first ^ 32'h10), "R4", "wrapped beat address",
                  r_second, r_first ^ 32'h10);
    endtask

    task automatic set_lock(input logic [3:0] m);
        @(negedge clk);
        lock_we = 1'b1; lock_wdata = m;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        flash_rvalid = 1'b0;
        flash_rdata  = '0;
        do_reset();
        // R11: idle outputs after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #2;
            check(!flash_req && !fetch_valid && !fetch_stall, "R11", "idle outputs",
                  {29'd0, flash_req, fetch_valid, fetch_stall}, 32'd0);
        end

        // Vector table: fills, hits and round-robin replacement (R7) from reset.
        for (int i = 0; i < NV; i++) expect_fetch(V_ADDR[i], V_REQS[i], "R7");

        // R11 + R5: fresh reset leaves the cache empty, then a full line hits.
        do_reset();
        expect_fetch(32'h0000_1000, 2, "R11");
        for (int i = 0; i < 8; i++) expect_fetch(32'h0000_1000 + 32'(4 * i), 0, "R5");

        // R6: way 0 pinned holds 0x1000 through four more fills of set 0.
        set_lock(4'b0001);
        expect_fetch(32'h0000_2000, 2, "R7");
        expect_fetch(32'h0000_3000, 2, "R7");
        expect_fetch(32'h0000_4000, 2, "R7");
        expect_fetch(32'h0000_5000, 2, "R7");
        expect_fetch(32'h0000_1000, 0, "R6");
        expect_fetch(32'h0000_2000, 2, "R6");

        // R8: everything pinned -> uncached single-beat service.
        set_lock(4'b1111);
        expect_fetch(32'h0000_6008, 1, "R8");
        expect_fetch(32'h0000_6008, 1, "R8");
        expect_fetch(32'h0000_5000, 0, "R6");

        // R9: preload into pinned way 2 (held 0x2000).
        @(negedge clk);
        preload_en = 1'b1; preload_way = 2'd2;
        expect_fetch(32'h0000_7000, 2, "R9");
        @(negedge clk);
        preload_en = 1'b0;
        expect_fetch(32'h0000_7004, 0, "R9");
        expect_fetch(32'h0000_2000, 1, "R9");

        // R10: only way 2 pinned, invalidate-all.
        set_lock(4'b0100);
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        expect_fetch(32'h0000_7000, 0, "R10");
        expect_fetch(32'h0000_5000, 2, "R10");

        check(!overlap, "R4", "single outstanding request", 32'(overlap), 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule